// File: doc/BRIEF.md
# Serial Equalizer Control Receiver

This block takes 8-bit command words over a three-line serial link and keeps the switch state of a fourteen-band stereo graphic equalizer. The link has a serial clock, a data line and a strobe. The three lines run slower than the system clock and have no fixed phase relation to it. They pass through a synchronizer. A bit is taken on each rising edge of the serial clock, and a full word is acted on when the strobe rises.

A word with its top bit set is a band-select word. It names the band that later gain words change, and it sets the gain range of each channel. A word with its top bit clear is a gain word. It stores a boost or cut direction and a six-bit resistor-switch pattern into the selected band. The selected band is kept between words, so a host can step the gain of one band by sending gain words only.

The outputs are one boost-side and one cut-side enable per switch per band, plus one range select per channel. They drive an external resistor network.

Top module: `eqctl_top`

## Requirements
- R1: Serial bits are sampled on rising edges of `ser_clk`. The least significant bit comes first, so the eighth bit sampled before a strobe becomes bit 7 of the word.
- R2: A word takes effect on the rising edge of `ser_strobe` only if at least eight bits were sampled since the previous strobe or reset. A strobe that follows fewer bits changes no output.
- R3: A word with bit 7 = 1 selects a band. Bit 5 sets `range_a` and bit 4 sets `range_b`, where 1 means the ±6 dB range and 0 means the ±12 dB range. Bit 6 has no effect.
- R4: Bits 3..0 of a band-select word are the band code. Codes 1 to 7 are the channel A bands and codes 8 to 14 are the channel B bands. Code c owns output bits [(c-1)*6 +: 6]. Codes 0 and 15 select no band.
- R5: A word with bit 7 = 0 is a gain word, and it writes the selected band. If bit 6 = 1, bits 5..0 of the word appear on that band's `boost_en` slice and its `cut_en` slice is zero. If bit 6 = 0, the pattern appears on `cut_en` and `boost_en` is zero. The pattern bits from bit 5 down to bit 0 weigh 1, 2, 3, 4, 5 and 9 dB.
- R6: A gain word with bits 5..0 all zero makes the band flat: both of its slices are zero whatever bit 6 holds. No band ever has boost and cut enables on at the same time.
- R7: The selected band persists. A run of gain words with no band-select word between them always targets the same band.
- R8: A gain word received while code 0 or 15 is selected changes no band.
- R9: Synchronous reset (`rst` high) makes every band flat, sets both ranges to ±12 dB and selects no band.
- R10: Serial clock edges seen while the strobe is high are discarded. After each strobe the shift register is empty, so a later strobe needs eight fresh bits.
- R11: When more than eight bits arrive before a strobe, only the last eight sampled form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, least significant bit first |
| ser_strobe | input | 1 | Word load strobe, acts on its rising edge |
| boost_en | output | 84 | Boost-side switch enables, 6 per band, band code 1 in the low bits |
| cut_en | output | 84 | Cut-side switch enables, 6 per band, same layout |
| range_a | output | 1 | Channel A range: 1 = ±6 dB, 0 = ±12 dB |
| range_b | output | 1 | Channel B range: 1 = ±6 dB, 0 = ±12 dB |

## Verification
The bench builds the block with a three-stage synchronizer instead of the default two. This lengthens the path from a serial edge to a register update and shows that the command timing does not depend on the synchronizer depth. The slow serial timing it uses reaches the cases that depend on edge order: clock edges while the strobe is high, strobes after a short word, words longer than eight bits, and gain words with no band selected. It also covers the edge band codes 0, 1, 7, 8, 14 and 15.

// File: rtl/eqctl_pkg.sv
package eqctl_pkg;
    parameter int WORD_W       = 8;
    parameter int SW_W         = 6;
    parameter int BANDS_PER_CH = 7;
    parameter int NUM_CH       = 2;
    localparam int NUM_BANDS   = BANDS_PER_CH * NUM_CH;
    localparam int CODE_W      = $clog2(NUM_BANDS + 2);
    localparam int EN_W        = NUM_BANDS * SW_W;
    localparam int CNT_W       = $clog2(WORD_W + 1);

    // bit positions inside a command word
    localparam int KIND_BIT    = WORD_W - 1;
    localparam int DIR_BIT     = WORD_W - 2;
    localparam int RANGE_A_BIT = 5;
    localparam int RANGE_B_BIT = 4;

    typedef struct packed {
        logic            boost;
        logic [SW_W-1:0] pat;
    } band_cfg_t;
endpackage

// File: rtl/eqctl_sync.sv
module eqctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lvl = st_q.pipe[STAGES-1];
endmodule

// File: rtl/eqctl_shift.sv
module eqctl_shift
    import eqctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sdat,
    input  logic              sstb,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              sclk_last;
        logic              stb_last;
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [WORD_W-1:0] word;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      sclk_rise, stb_rise;

    assign sclk_rise = sclk & ~st_q.sclk_last;
    assign stb_rise  = sstb & ~st_q.stb_last;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_last = sclk;
        st_d.stb_last  = sstb;
        st_d.valid     = 1'b0;
        if (stb_rise) begin
            if (st_q.cnt == CNT_W'(WORD_W)) begin
                st_d.valid = 1'b1;
                st_d.word  = st_q.sr;
            end
            st_d.sr  = '0;
            st_d.cnt = '0;
        end else if (sclk_rise && !sstb) begin
            st_d.sr = {sdat, st_q.sr[WORD_W-1:1]};
            if (st_q.cnt != CNT_W'(WORD_W)) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_valid = st_q.valid;
    assign word       = st_q.word;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_W'(WORD_W));

    p_short_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && st_q.cnt != CNT_W'(WORD_W)) |=> !st_q.valid);

    p_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |-> (st_q.cnt == '0 && st_q.sr == '0));

    p_strobe_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (sstb && !stb_rise && sclk_rise) |=> ($stable(st_q.sr) && $stable(st_q.cnt)));
endmodule

// File: rtl/eqctl_bank.sv
module eqctl_bank
    import eqctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic [EN_W-1:0]   boost_en,
    output logic [EN_W-1:0]   cut_en,
    output logic              range_a,
    output logic              range_b
);
    typedef struct packed {
        band_cfg_t [NUM_BANDS-1:0] cfg;
        logic [CODE_W-1:0]         sel;
        logic                      rng_a;
        logic                      rng_b;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     sel_hit;

    assign sel_hit = (st_q.sel != '0) && (st_q.sel <= CODE_W'(NUM_BANDS));

    always_comb begin
        st_d = st_q;
        if (word_valid) begin
            if (word[KIND_BIT]) begin
                st_d.sel   = word[CODE_W-1:0];
                st_d.rng_a = word[RANGE_A_BIT];
                st_d.rng_b = word[RANGE_B_BIT];
            end else if (sel_hit) begin
                for (int b = 0; b < NUM_BANDS; b++) begin
                    if (st_q.sel == CODE_W'(b + 1)) begin
                        st_d.cfg[b].boost = word[DIR_BIT];
                        st_d.cfg[b].pat   = word[SW_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
        assign boost_en[g*SW_W +: SW_W] = st_q.cfg[g].boost ? st_q.cfg[g].pat : '0;
        assign cut_en[g*SW_W +: SW_W]   = st_q.cfg[g].boost ? '0 : st_q.cfg[g].pat;
    end

    assign range_a = st_q.rng_a;
    assign range_b = st_q.rng_b;

    p_range_load_r3: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word[KIND_BIT]) |=>
            (range_a == $past(word[RANGE_A_BIT]) && range_b == $past(word[RANGE_B_BIT])));

    p_never_both_r6: assert property (@(posedge clk) disable iff (rst)
        (boost_en & cut_en) == '0);

    p_sticky_sel_r7: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word[KIND_BIT]) |=> $stable(st_q.sel));

    p_idle_gain_r8: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word[KIND_BIT] && !sel_hit) |=> $stable(st_q.cfg));

    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (boost_en == '0 && cut_en == '0 && !range_a && !range_b && st_q.sel == '0));
endmodule

// File: rtl/eqctl_top.sv
module eqctl_top
    import eqctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            ser_strobe,
    output logic [EN_W-1:0] boost_en,
    output logic [EN_W-1:0] cut_en,
    output logic            range_a,
    output logic            range_b
);
    localparam int LINES = 3;

    logic [LINES-1:0]  lines_s;
    logic              word_valid;
    logic [WORD_W-1:0] word;

    eqctl_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({ser_strobe, ser_data, ser_clk}),
        .lvl (lines_s)
    );

    eqctl_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .sclk       (lines_s[0]),
        .sdat       (lines_s[1]),
        .sstb       (lines_s[2]),
        .word_valid (word_valid),
        .word       (word)
    );

    eqctl_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .word_valid (word_valid),
        .word       (word),
        .boost_en   (boost_en),
        .cut_en     (cut_en),
        .range_a    (range_a),
        .range_b    (range_b)
    );
endmodule

// File: tb/sim_eqctl_top.sv
module sim_eqctl_top;
    import eqctl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
    logic [EN_W-1:0] boost_en, cut_en;
    logic range_a, range_b;

    always #5 clk = ~clk;

    eqctl_top #(.SYNC_STAGES(3)) u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .boost_en(boost_en), .cut_en(cut_en),
        .range_a(range_a), .range_b(range_b)
    );

    typedef struct {
        logic [EN_W-1:0] boost;
        logic [EN_W-1:0] cut;
        logic            ra;
        logic            rb;
        string           tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int checks = 0, errors = 0;
    bit done = 0;

    // reference state from the requirements
    logic [SW_W-1:0] m_pat[1:NUM_BANDS];
    logic            m_boost[1:NUM_BANDS];
    int              m_sel;
    logic            m_ra, m_rb;

    task automatic model_reset();
        for (int b = 1; b <= NUM_BANDS; b++) begin m_pat[b] = '0; m_boost[b] = 1'b0; end
        m_sel = 0; m_ra = 1'b0; m_rb = 1'b0;
    endtask

    task automatic model_word(input logic [7:0] w);
        if (w[7]) begin
            m_sel = int'(w[3:0]); m_ra = w[5]; m_rb = w[4];
        end else if (m_sel >= 1 && m_sel <= NUM_BANDS) begin
            m_boost[m_sel] = w[6]; m_pat[m_sel] = w[5:0];
        end
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        e.boost = '0; e.cut = '0;
        for (int b = 1; b <= NUM_BANDS; b++) begin
            if (m_pat[b] != '0) begin
                if (m_boost[b]) e.boost[(b-1)*SW_W +: SW_W] = m_pat[b];
                else            e.cut[(b-1)*SW_W +: SW_W]   = m_pat[b];
            end
        end
        e.ra = m_ra; e.rb = m_rb; e.tag = tag;
        q.push_back(e);
        -> chk_ev;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b; wait_n(4);
        ser_clk = 1'b1; wait_n(4);
        ser_clk = 1'b0; wait_n(2);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic pulse_strobe();
        wait_n(4); ser_strobe = 1'b1; wait_n(6); ser_strobe = 1'b0; wait_n(12);
    endtask

    // full word, strobe, model update, scoreboard push
    task automatic send_word(input logic [7:0] w, input string tag);
        send_bits({8'h00, w}, 8);
        pulse_strobe();
        model_word(w);
        expect_now(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(chk_ev);
            @(posedge clk); #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (boost_en !== e.boost || cut_en !== e.cut || range_a !== e.ra || range_b !== e.rb) begin
                    errors++;
                    $display("FAIL %s: boost=%h cut=%h ra=%b rb=%b expected boost=%h cut=%h ra=%b rb=%b",
                             e.tag, boost_en, cut_en, range_a, range_b, e.boost, e.cut, e.ra, e.rb);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        wait_n(5); rst = 1'b0; wait_n(3);
        expect_now("R9 reset state");

        // R3 band select with bit 6 set; ranges A=6dB, B=12dB
        send_word(8'b1110_0011, "R3 select code 3 range A 6dB bit6 ignored");
        // R1 R5 boost pattern, asymmetric to expose bit order
        send_word(8'b0100_0001, "R1 LSB first boost 9dB switch only");
        send_word(8'b0111_1010, "R5 boost pattern on band 3");
        // R7 same band, cut
        send_word(8'b0000_0101, "R7 sticky band cut pattern");
        // R6 flat with boost flag set
        send_word(8'b0100_0000, "R6 flat word bit6 high");
        // R4 channel B band 10, range B 6dB
        send_word(8'b1001_1010, "R4 select code 10 range B");
        send_word(8'b0110_1111, "R5 boost band 10");
        // R4 boundary bands
        send_word(8'b1000_0001, "R4 select code 1");
        send_word(8'b0010_0000, "R4 cut band 1");
        send_word(8'b1000_0111, "R4 select code 7");
        send_word(8'b0100_0011, "R4 boost band 7");
        send_word(8'b1000_1000, "R4 select code 8");
        send_word(8'b0000_0010, "R4 cut band 8");
        send_word(8'b1011_1110, "R4 select code 14 both 6dB");
        send_word(8'b0111_1111, "R4 boost band 14");
        // R8 no band selected
        send_word(8'b1000_0000, "R8 select code 0");
        send_word(8'b0111_0111, "R8 gain with code 0 ignored");
        send_word(8'b1000_1111, "R8 select code 15");
        send_word(8'b0001_1100, "R8 gain with code 15 ignored");
        send_word(8'b1000_0011, "R7 reselect code 3");

        // R2 short word: 5 bits of a gain word then strobe
        send_bits(16'h003F, 5);
        pulse_strobe();
        expect_now("R2 short word ignored");

        // R11 ten bits: two leading junk bits, then a word
        send_bits({6'b0, 8'b0100_1100, 2'b11}, 10);
        pulse_strobe();
        model_word(8'b0100_1100);
        expect_now("R11 last eight bits used");

        // R10 clock edges while strobe high are discarded
        wait_n(4); ser_strobe = 1'b1; wait_n(6);
        send_bits(16'h0033, 8);
        ser_strobe = 1'b0; wait_n(12);
        pulse_strobe();
        expect_now("R10 bits under strobe discarded");

        // R10 register cleared after strobe: 3 bits then strobe ignored
        send_word(8'b0000_1001, "R10 normal word before partial");
        send_bits(16'h0007, 3);
        pulse_strobe();
        expect_now("R10 partial after strobe ignored");

        // R9 reset mid-run
        wait_n(2); rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(3);
        model_reset();
        expect_now("R9 reset clears bands and ranges");
        send_word(8'b0001_0001, "R9 no band selected after reset");

        wait_n(10);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule